// File: doc/BRIEF.md
# Windowed Watchdog Reset Supervisor

This block drives an active-low system reset from three synchronous inputs. The first is a supply-good flag from an external voltage comparator. The second is a trigger line from the supervised processor. The third is a timebase tick. A fixed clock drives all logic, and every duration is a parameter counted in ticks of the timebase.

When the supply becomes good, the reset stays asserted for a power-on delay. After that delay the block runs a windowed watchdog. Each cycle starts with a closed window, in which a trigger counts as a fault. An open window follows, and the processor must trigger within it. A missed or early trigger produces a fixed-width reset pulse. If three expiries in a row pass with no trigger, the block falls into a low-rate sleep pattern: a long release followed by a short reset pulse, repeated. Either edge of the trigger line ends the sleep pattern. A supply drop also ends it.

States and transitions:
- OFF → POR when supply is good.
- POR → CLOSED when the power-on delay ends.
- CLOSED → OPEN when the closed window ends. CLOSED → PULSE on a trigger (fault).
- OPEN → CLOSED on a trigger. OPEN → PULSE when the open window ends.
- PULSE → CLOSED when the pulse ends. PULSE → SLEEP_GAP when the pulse ends and the limit of missed cycles has been reached.
- SLEEP_GAP ↔ SLEEP_PULSE when each interval ends. Either sleep state → CLOSED on any trigger edge.
- Any state → OFF while supply is low.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: While `supply_ok` is low, and while `rst_n` is low, `rst_out_n` is 0. A clock edge with `supply_ok` low puts the block in OFF.
- R2: After `supply_ok` rises, `rst_out_n` stays 0 for POR_TICKS ticks. The count starts at the first clock edge that sees the supply high. POR_TICKS equals WD_TICKS, or WD_TICKS/4 when QUARTER_POR is 1.
- R3: A fall of `supply_ok` in any state, sleep included, drives `rst_out_n` to 0 in the same cycle. When the supply recovers, the full power-on delay runs again.
- R4: Trigger edges have no effect during the power-on delay or during a reset pulse.
- R5: `trig_in` passes through two synchronizer flops and an edge register. A change of `trig_in` before clock edge k takes effect at edge k+2. It is first visible on `rst_out_n` after three edges.
- R6: Each interval lasts its number of tick cycles, and the state changes on the edge that samples the last tick. A watchdog cycle is CW_TICKS of closed window and then OW_TICKS of open window, both with `rst_out_n` at 1.
- R7: A rising trigger edge in the open window restarts the closed window. It also clears the count of missed cycles.
- R8: An open window that ends with no trigger drives `rst_out_n` to 0 for PULSE_TICKS, then restarts the closed window. Each such expiry adds one to the count of missed cycles.
- R9: A rising trigger edge in the closed window is a fault. It gives a PULSE_TICKS reset pulse, then a new closed window, and does not change the count of missed cycles.
- R10: A trigger edge seen in the cycle in which a window ends belongs to the window that is ending. In the closed window it is a fault. In the open window it is a valid trigger.
- R11: When the pulse of the MISS_LIMIT-th consecutive expiry ends, the block enters sleep. In sleep, `rst_out_n` repeats SLEEP_GAP_TICKS at 1 followed by SLEEP_PULSE_TICKS at 0.
- R12: In sleep, a rising or falling trigger edge returns the block to a fresh closed window with the count of missed cycles cleared.
- R13: Outside sleep, falling trigger edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's state |
| supply_ok | input | 1 | Comparator result: supply above threshold (synchronous) |
| trig_in | input | 1 | Watchdog trigger from the processor (asynchronous) |
| tick | input | 1 | Timebase tick, one clock wide, qualifies interval counting |
| rst_out_n | output | 1 | Active-low reset to the system |

## Verification
Two functions can fall in the same cycle: the end of a window and a synchronized trigger edge. The bench holds the tick high and places a trigger change three edges before the last cycle of the closed window. The release interval must then be exactly CW_TICKS, followed by a fault pulse. The same placement at the end of the open window must extend the release by one full watchdog cycle. A reference model tracks every cycle, so random trigger rates and random tick gaps also land edges on window boundaries, and each outcome is compared against the model.

// File: rtl/wdsup_pkg.sv
`timescale 1ns/1ps
package wdsup_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_POR,
        S_CLOSED,
        S_OPEN,
        S_PULSE,
        S_SLEEP_GAP,
        S_SLEEP_PULSE
    } sup_state_e;

    // States in which the system reset is released
    function automatic logic releases(input sup_state_e s);
        return (s == S_CLOSED) || (s == S_OPEN) || (s == S_SLEEP_GAP);
    endfunction

    function automatic logic sleeping(input sup_state_e s);
        return (s == S_SLEEP_GAP) || (s == S_SLEEP_PULSE);
    endfunction

endpackage

// File: rtl/trig_edge_sync.sv
`timescale 1ns/1ps
module trig_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], async_in};
    end

    // Edge register is the last stage; compare against the synchronized value
    assign rise =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];

endmodule

// File: rtl/tick_interval_timer.sv
`timescale 1ns/1ps
module tick_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    assign done = tick && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/wdt_reset_supervisor.sv
`timescale 1ns/1ps
module wdt_reset_supervisor
    import wdsup_pkg::*;
#(
    parameter int WD_TICKS          = 10,
    parameter bit QUARTER_POR       = 1'b0,
    parameter int CW_TICKS          = 8,
    parameter int OW_TICKS          = 4,
    parameter int PULSE_TICKS       = 2,
    parameter int SLEEP_GAP_TICKS   = 40,
    parameter int SLEEP_PULSE_TICKS = 3,
    parameter int MISS_LIMIT        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic trig_in,
    input  logic tick,
    output logic rst_out_n
);
    localparam int POR_TICKS = QUARTER_POR ? (WD_TICKS / 4) : WD_TICKS;
    localparam int MAX_A     = (POR_TICKS > CW_TICKS) ? POR_TICKS : CW_TICKS;
    localparam int MAX_B     = (OW_TICKS > PULSE_TICKS) ? OW_TICKS : PULSE_TICKS;
    localparam int MAX_C     = (SLEEP_GAP_TICKS > SLEEP_PULSE_TICKS) ? SLEEP_GAP_TICKS : SLEEP_PULSE_TICKS;
    localparam int MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_DUR   = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W     = $clog2(MAX_DUR + 1);
    localparam int MISS_W    = $clog2(MISS_LIMIT + 1);

    sup_state_e        state_q, state_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic [CNT_W-1:0]  dur;
    logic              trig_rise, trig_fall, t_done, restart;

    trig_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise     (trig_rise),
        .fall     (trig_fall)
    );

    tick_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .limit   (dur),
        .done    (t_done)
    );

    // Length of the interval owned by the current state
    always_comb begin
        unique case (state_q)
            S_POR:         dur = CNT_W'(POR_TICKS);
            S_CLOSED:      dur = CNT_W'(CW_TICKS);
            S_OPEN:        dur = CNT_W'(OW_TICKS);
            S_PULSE:       dur = CNT_W'(PULSE_TICKS);
            S_SLEEP_GAP:   dur = CNT_W'(SLEEP_GAP_TICKS);
            S_SLEEP_PULSE: dur = CNT_W'(SLEEP_PULSE_TICKS);
            default:       dur = CNT_W'(POR_TICKS);
        endcase
    end

    // Next state; a trigger edge in the ending cycle belongs to the ending window
    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        if (!supply_ok) begin
            state_d = S_OFF;
            miss_d  = '0;
        end else begin
            unique case (state_q)
                S_OFF: state_d = S_POR;
                S_POR: begin
                    miss_d = '0;
                    if (t_done) state_d = S_CLOSED;
                end
                S_CLOSED: begin
                    if (trig_rise)   state_d = S_PULSE;
                    else if (t_done) state_d = S_OPEN;
                end
                S_OPEN: begin
                    if (trig_rise) begin
                        state_d = S_CLOSED;
                        miss_d  = '0;
                    end else if (t_done) begin
                        state_d = S_PULSE;
                        if (miss_q < MISS_W'(MISS_LIMIT)) miss_d = miss_q + 1'b1;
                    end
                end
                S_PULSE: begin
                    if (t_done)
                        state_d = (miss_q >= MISS_W'(MISS_LIMIT)) ? S_SLEEP_GAP : S_CLOSED;
                end
                S_SLEEP_GAP, S_SLEEP_PULSE: begin
                    if (trig_rise || trig_fall) begin
                        state_d = S_CLOSED;
                        miss_d  = '0;
                    end else if (t_done) begin
                        state_d = (state_q == S_SLEEP_GAP) ? S_SLEEP_PULSE : S_SLEEP_GAP;
                    end
                end
                default: state_d = S_OFF;
            endcase
        end
    end

    assign restart = (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            miss_q  <= miss_d;
        end
    end

    // Output decode; supply gating keeps power-down reset immediate
    always_comb begin
        rst_out_n = supply_ok && releases(state_q);
    end

    // R1
    off_on_supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> state_q == S_OFF);

    // R4
    por_ignores_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POR && trig_rise && !t_done && supply_ok) |=> state_q == S_POR);

    // R8
    open_expiry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OPEN && t_done && !trig_rise && supply_ok)
        |=> (state_q == S_PULSE && miss_q == $past(miss_q) + MISS_W'(1)));

    // R9
    closed_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CLOSED && trig_rise && supply_ok) |=> state_q == S_PULSE);

    // R12
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping(state_q) && (trig_rise || trig_fall) && supply_ok)
        |=> (state_q == S_CLOSED && miss_q == '0));

    // R11
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q <= MISS_W'(MISS_LIMIT));

endmodule

// File: tb/sim_wdt_reset_supervisor.sv
`timescale 1ns/1ps
module sim_wdt_reset_supervisor;
    localparam int WD   = 10;
    localparam int POR  = WD;
    localparam int CW   = 8;
    localparam int OW   = 4;
    localparam int PUL  = 2;
    localparam int SGAP = 40;
    localparam int SPUL = 3;
    localparam int MISS = 3;

    localparam int M_OFF = 0, M_POR = 1, M_CL = 2, M_OP = 3, M_PU = 4, M_SG = 5, M_SP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply = 1'b0;
    logic trig = 1'b0;
    logic tick = 1'b0;
    logic rst_out_n;

    int n_tests = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    int cycles = 0;

    always #2 clk = ~clk;

    wdt_reset_supervisor #(
        .WD_TICKS(WD), .QUARTER_POR(1'b0), .CW_TICKS(CW), .OW_TICKS(OW),
        .PULSE_TICKS(PUL), .SLEEP_GAP_TICKS(SGAP), .SLEEP_PULSE_TICKS(SPUL),
        .MISS_LIMIT(MISS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply), .trig_in(trig),
        .tick(tick), .rst_out_n(rst_out_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // ---------------- reference model built from the requirements ----------------
    int    m_st = M_OFF, m_cnt = 0, m_miss = 0, m_nx;
    logic  m_s1 = 0, m_s2 = 0, m_s3 = 0, m_rise, m_fall, m_done;
    string m_why = "R1";

    function automatic int m_dur(input int st);
        case (st)
            M_POR: return POR;
            M_CL:  return CW;
            M_OP:  return OW;
            M_PU:  return PUL;
            M_SG:  return SGAP;
            M_SP:  return SPUL;
            default: return POR;
        endcase
    endfunction

    function automatic logic m_rel(input int st);
        return (st == M_CL) || (st == M_OP) || (st == M_SG);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = M_OFF; m_cnt = 0; m_miss = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_why = "R1";
        end else begin
            m_rise = m_s2 & ~m_s3;
            m_fall = ~m_s2 & m_s3;
            m_done = tick && (m_cnt == m_dur(m_st) - 1);
            m_nx = m_st;
            if (!supply) begin
                m_nx = M_OFF; m_miss = 0; m_why = "R3";
            end else begin
                case (m_st)
                    M_OFF: begin m_nx = M_POR; m_why = "R2"; end
                    M_POR: begin m_miss = 0; if (m_done) begin m_nx = M_CL; m_why = "R2"; end end
                    M_CL: begin
                        if (m_rise) begin m_nx = M_PU; m_why = m_done ? "R10" : "R9"; end
                        else if (m_done) begin m_nx = M_OP; m_why = "R6"; end
                    end
                    M_OP: begin
                        if (m_rise) begin m_nx = M_CL; m_miss = 0; m_why = m_done ? "R10" : "R7"; end
                        else if (m_done) begin m_nx = M_PU; m_miss++; m_why = "R8"; end
                    end
                    M_PU: if (m_done) begin
                        if (m_miss >= MISS) begin m_nx = M_SG; m_why = "R11"; end
                        else m_nx = M_CL;
                    end
                    default: begin
                        if (m_rise || m_fall) begin m_nx = M_CL; m_miss = 0; m_why = "R12"; end
                        else if (m_done) m_nx = (m_st == M_SG) ? M_SP : M_SG;
                    end
                endcase
            end
            if (m_nx != m_st) m_cnt = 0;
            else if (tick) m_cnt++;
            m_st = m_nx;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the edge
    always begin
        @(posedge clk);
        #1;
        if (chk_on)
            check(rst_out_n === (supply && m_rel(m_st)), m_why, int'(rst_out_n),
                  int'(supply && m_rel(m_st)));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 190000);
            finish_run();
        end
    end

    // Length of a run of constant output, sampled at negedges
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (rst_out_n === lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'd4242));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(rst_out_n === 1'b0, "R1", int'(rst_out_n), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        tick = 1'b1;
        repeat (10) @(negedge clk);
        check(rst_out_n === 1'b0, "R1", int'(rst_out_n), 0);

        // R2 / R4: power-on delay length while the trigger toggles
        supply = 1'b1;
        @(negedge clk);
        n = 0;
        while (rst_out_n === 1'b0 && n < 1000) begin
            n++;
            trig = (n < POR - 4) ? n[0] : 1'b1;
            @(negedge clk);
        end
        check(n == POR, "R4", n, POR);
        check(n == POR, "R2", n, POR);

        // R6 / R8 / R11: no triggers, three expiries then sleep pattern
        for (int k = 0; k < MISS; k++) begin
            run_len(1'b1, n);
            check(n == CW + OW, "R6", n, CW + OW);
            run_len(1'b0, n);
            check(n == PUL, "R8", n, PUL);
        end
        run_len(1'b1, n);
        check(n == SGAP, "R11", n, SGAP);
        run_len(1'b0, n);
        check(n == SPUL, "R11", n, SPUL);
        run_len(1'b1, n);
        check(n == SGAP, "R11", n, SGAP);

        // R12 / R5: falling edge wakes from the sleep pulse
        tick = 1'b0;
        trig = 1'b0;
        repeat (2) @(negedge clk);
        check(rst_out_n === 1'b0, "R5", int'(rst_out_n), 0);
        @(negedge clk);
        check(rst_out_n === 1'b1, "R12", int'(rst_out_n), 1);

        // R5 / R9: rising edge in the closed window is a fault
        trig = 1'b1;
        repeat (2) @(negedge clk);
        check(rst_out_n === 1'b1, "R5", int'(rst_out_n), 1);
        @(negedge clk);
        check(rst_out_n === 1'b0, "R9", int'(rst_out_n), 0);
        tick = 1'b1;
        run_len(1'b0, n);
        check(n == PUL, "R9", n, PUL);

        // R13: falling edge in the closed window has no effect
        tick = 1'b0;
        trig = 1'b0;
        n = 0;
        repeat (6) begin
            @(negedge clk);
            if (rst_out_n !== 1'b1) n++;
        end
        check(n == 0, "R13", n, 0);

        // R7: valid trigger early in the open window
        tick = 1'b1;
        n = 0;
        while (rst_out_n === 1'b1 && n < 1000) begin
            n++;
            if (n == CW) trig = 1'b1;
            @(negedge clk);
        end
        check(n == 2 * CW + OW + 2, "R7", n, 2 * CW + OW + 2);
        run_len(1'b0, n);
        check(n == PUL, "R8", n, PUL);

        // R10: trigger edge on the last closed cycle is a fault
        trig = 1'b0;
        n = 0;
        while (rst_out_n === 1'b1 && n < 1000) begin
            n++;
            if (n == CW - 2) trig = 1'b1;
            @(negedge clk);
        end
        check(n == CW, "R10", n, CW);
        run_len(1'b0, n);

        // R10: trigger edge on the last open cycle is valid
        trig = 1'b0;
        n = 0;
        while (rst_out_n === 1'b1 && n < 1000) begin
            n++;
            if (n == CW + OW - 2) trig = 1'b1;
            @(negedge clk);
        end
        check(n == 2 * (CW + OW), "R10", n, 2 * (CW + OW));

        // R3: supply drop forces reset in the same cycle
        run_len(1'b0, n);
        repeat (3) @(negedge clk);
        supply = 1'b0;
        #1;
        check(rst_out_n === 1'b0, "R3", int'(rst_out_n), 0);
        repeat (4) @(negedge clk);
        supply = 1'b1;

        // Random phases: busy, sparse, silent (sleep), waking
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 5000; i++) begin
                @(negedge clk);
                tick = (($urandom % 3) != 0);
                case (ph)
                    0: if ($urandom % 6 == 0) trig = ~trig;
                    1: if ($urandom % 40 == 0) trig = ~trig;
                    3: if ($urandom % 25 == 0) trig = ~trig;
                    default: ;
                endcase
                if (ph != 2 && $urandom % 1500 == 0) supply = 1'b0;
                else if (!supply && $urandom % 8 == 0) supply = 1'b1;
            end
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule